// File: doc/BRIEF.md
# Time-Tagged Sample Stream Packetizer

This block collects complex or real samples from an acquisition chain and turns them into fixed-length byte packets for a UDP transmit path. Each packet opens with a 12-byte metadata header: a format code, a flag byte, the number of samples carried, the GPS second, and the position inside the packet of the sample that coincides with the one-pulse-per-second timing mark. After the header come the samples, packed in one of several selectable layouts. Each field within a sample is emitted in a selectable byte order.

The sample side uses valid/ready. The block gathers a whole packet into local storage because the timing-mark position must appear in the header. It then stops accepting input while it drives the packet out as a byte stream, with start and end markers and output back-pressure. The PPS input is asynchronous and is synchronised internally. Configuration is sampled at packet boundaries only. IP/UDP framing, the MAC and any control protocol sit outside this block.

Top module: `psp_packetizer`

## Requirements
- R1: A packet is 12 header bytes, all multi-byte fields most-significant byte first, followed by the payload. Header byte 0 is the format code, byte 1 holds flags (bit 0 = timing mark present, other bits zero), bytes 2-3 hold the sample count, bytes 4-7 hold the GPS seconds, bytes 8-9 hold the mark index, and bytes 10-11 are zero. `out_sop` is high on header byte 0 only and `out_eop` is high on the last payload byte only.
- R2: Format code 0 packs each sample as 4 bytes: the I field `in_data[47:32]` and then the Q field `in_data[15:0]`.
- R3: Format code 1 packs each sample as 2 bytes taken from `in_data[15:0]`, back to back.
- R4: Format codes 2 and 3 pack each sample as 8 bytes: the I field `in_data[63:32]` and then the Q field `in_data[31:0]`. The header carries the code as given.
- R5: With `cfg_le`=0 each payload field is emitted most-significant byte first. With `cfg_le`=1 it is emitted least-significant byte first. The header order never changes.
- R6: `cfg_pkt_len` gives the packet length in samples. A value of 0 acts as 1, and values above MAX_SAMPLES act as MAX_SAMPLES. After the end byte the next accepted sample opens a new packet with a fresh header.
- R7: Format, byte order and length are taken when a packet's first sample is accepted. Later configuration changes do not affect that packet.
- R8: The first sample accepted on or after a synchronised PPS rising edge is tagged. That packet has flag bit 0 set, the tagged sample's zero-based position as mark index, and the `gps_sec` value sampled at that edge as seconds.
- R9: A packet with no tagged sample has flag bit 0 clear, mark index 0xFFFF, and as seconds the value latched at the most recent PPS edge (0 if none since reset).
- R10: While a packet is being emitted, `in_ready` is low. When `out_valid` is high and `out_ready` is low, the output byte and markers hold.
- R11: `overflow` sets when `in_valid` is high, `in_ready` is low and the output is stalled (`out_valid` high, `out_ready` low). Once set, it stays set until reset.
- R12: After reset, `in_ready`=1, `out_valid`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 2 | Packing format code |
| cfg_le | input | 1 | Payload field byte order, 1 = least-significant first |
| cfg_pkt_len | input | 16 | Packet length in samples |
| pps_in | input | 1 | Asynchronous one-pulse-per-second mark |
| gps_sec | input | 32 | Current GPS seconds count |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample accepted when high with in_valid |
| in_data | input | 64 | Sample word, I in upper half, Q in lower half |
| out_ready | input | 1 | Downstream can take a byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| overflow | output | 1 | Sticky input overflow flag |

## Verification
Two events can land on the same clock edge. The first is the timing-mark tag. The second is the packet close triggered by the final sample. The bench provokes this by raising PPS just before the last sample of a packet. It then expects that packet's header to report the mark at index length-1, with the seconds latched at that edge, and it expects the following packet to carry no mark. A second overlap is an input offered while the output is stalled mid-packet. The bench judges this by the overflow flag, by `in_ready` staying low, and by the held output byte staying unchanged.

// File: rtl/psp_pkg.sv
package psp_pkg;
  localparam int HDR_BYTES = 12;
  localparam logic [1:0] FMT_IQ32  = 2'd0;
  localparam logic [1:0] FMT_RAW16 = 2'd1;

  // log2 of the payload bytes per sample
  function automatic logic [1:0] bps_log2(input logic [1:0] fmt);
    case (fmt)
      FMT_IQ32:  return 2'd2;
      FMT_RAW16: return 2'd1;
      default:   return 2'd3;
    endcase
  endfunction

  // byte k of one packed sample
  function automatic logic [7:0] payload_byte(input logic [1:0] fmt, input logic le,
                                              input logic [63:0] w, input logic [2:0] k);
    logic [31:0] f;
    logic [1:0]  pos, top, sh;
    case (fmt)
      FMT_RAW16: begin f = {16'h0, w[15:0]}; pos = {1'b0, k[0]}; top = 2'd1; end
      FMT_IQ32: begin
        f   = k[1] ? {16'h0, w[15:0]} : {16'h0, w[47:32]};
        pos = {1'b0, k[0]};
        top = 2'd1;
      end
      default: begin f = k[2] ? w[31:0] : w[63:32]; pos = k[1:0]; top = 2'd3; end
    endcase
    sh = le ? pos : top - pos;
    return f[{sh, 3'b000} +: 8];
  endfunction

  function automatic logic [7:0] header_byte(input logic [3:0] idx, input logic [7:0] fid,
                                             input logic [7:0] flags, input logic [15:0] cnt,
                                             input logic [31:0] sec, input logic [15:0] mk);
    case (idx)
      4'd0:    return fid;
      4'd1:    return flags;
      4'd2:    return cnt[15:8];
      4'd3:    return cnt[7:0];
      4'd4:    return sec[31:24];
      4'd5:    return sec[23:16];
      4'd6:    return sec[15:8];
      4'd7:    return sec[7:0];
      4'd8:    return mk[15:8];
      4'd9:    return mk[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic int unsigned clamp_len(input logic [15:0] req, input int unsigned maxs);
    if (req == 16'd0) return 1;
    if (32'(req) > maxs) return maxs;
    return 32'(req);
  endfunction
endpackage

// File: rtl/psp_pps_tagger.sv
module psp_pps_tagger (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pps_in,
  input  logic [31:0] gps_sec,
  input  logic        consume,
  output logic        pend,
  output logic [31:0] pend_sec,
  output logic [31:0] last_sec
);
  logic [2:0]  sync_q;
  logic        rise;
  logic        pend_q;
  logic [31:0] pend_sec_q, last_sec_q;

  assign rise     = sync_q[1] & ~sync_q[2];
  assign pend     = pend_q | rise;
  assign pend_sec = rise ? gps_sec : pend_sec_q;
  assign last_sec = last_sec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q     <= '0;
      pend_q     <= 1'b0;
      pend_sec_q <= '0;
      last_sec_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pps_in};
      if (consume)   pend_q <= 1'b0;
      else if (rise) pend_q <= 1'b1;
      if (rise) begin
        pend_sec_q <= gps_sec;
        last_sec_q <= gps_sec;
      end
    end
  end

  // R8: an untaken mark stays pending
  a_r8_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !consume |=> pend_q);
endmodule

// File: rtl/psp_sample_store.sv
module psp_sample_store #(
  parameter int DEPTH = 16,
  parameter int W     = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/psp_byte_emitter.sv
module psp_byte_emitter
  import psp_pkg::*;
#(
  parameter int MAX_SAMPLES = 16,
  localparam int AW  = (MAX_SAMPLES > 1) ? $clog2(MAX_SAMPLES) : 1,
  localparam int CW  = $clog2(MAX_SAMPLES + 1),
  localparam int TOT = HDR_BYTES + 8 * MAX_SAMPLES,
  localparam int BW  = $clog2(TOT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    fmt,
  input  logic          le,
  input  logic [CW-1:0] hdr_cnt,
  input  logic          hdr_mark,
  input  logic [31:0]   hdr_sec,
  input  logic [15:0]   hdr_idx,
  input  logic [63:0]   rdata,
  output logic [AW-1:0] raddr,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          done
);
  logic          busy;
  logic [BW-1:0] bidx, total, pidx, sidx;
  logic [1:0]    lg;
  logic [2:0]    k;

  always_comb begin
    lg    = bps_log2(fmt);
    total = BW'(HDR_BYTES) + (BW'(hdr_cnt) << lg);
    pidx  = bidx - BW'(HDR_BYTES);
    sidx  = pidx >> lg;
    k     = 3'(pidx) & ((3'd1 << lg) - 3'd1);
  end

  assign raddr     = AW'(sidx);
  assign out_valid = busy;
  assign out_sop   = busy && (bidx == '0);
  assign out_eop   = busy && (bidx == total - BW'(1));
  assign done      = out_eop && out_ready;
  assign out_data  = (bidx < BW'(HDR_BYTES))
                   ? header_byte(4'(bidx), {6'b0, fmt}, {7'b0, hdr_mark}, 16'(hdr_cnt), hdr_sec, hdr_idx)
                   : payload_byte(fmt, le, rdata, k);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      bidx <= '0;
    end else if (start) begin
      busy <= 1'b1;
      bidx <= '0;
    end else if (busy && out_ready) begin
      if (out_eop) busy <= 1'b0;
      else         bidx <= bidx + BW'(1);
    end
  end

  // R10: a stalled byte holds
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !out_ready |=> busy && $stable(out_data) && $stable(out_sop) && $stable(out_eop));
  // R6: the emitted packet length stays within bounds
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (hdr_cnt != '0) && (32'(hdr_cnt) <= MAX_SAMPLES));
endmodule

// File: rtl/psp_packetizer.sv
module psp_packetizer
  import psp_pkg::*;
#(
  parameter int MAX_SAMPLES = 16,
  localparam int AW = (MAX_SAMPLES > 1) ? $clog2(MAX_SAMPLES) : 1,
  localparam int CW = $clog2(MAX_SAMPLES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_fmt,
  input  logic        cfg_le,
  input  logic [15:0] cfg_pkt_len,
  input  logic        pps_in,
  input  logic [31:0] gps_sec,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_data,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sop,
  output logic        out_eop,
  output logic        overflow
);
  logic [CW-1:0] cnt_q, cur_len, req_len, eff_len, hdr_cnt;
  logic [1:0]    cur_fmt;
  logic          cur_le;
  logic          accept, close, tag, boundary, emit_done;
  logic          pend;
  logic [31:0]   pend_sec, last_sec;
  logic          mark_q, hdr_mark;
  logic [15:0]   midx_q, hdr_idx;
  logic [31:0]   msec_q, hdr_sec;
  logic [AW-1:0] raddr;
  logic [63:0]   rdata;
  logic          ovf_q;

  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;
  assign boundary = in_ready && (cnt_q == '0);
  assign req_len  = CW'(clamp_len(cfg_pkt_len, MAX_SAMPLES));
  assign eff_len  = (cnt_q == '0) ? req_len : cur_len;
  assign close    = accept && (cnt_q == eff_len - CW'(1));
  assign tag      = accept && pend && !mark_q;
  assign overflow = ovf_q;

  psp_pps_tagger u_pps (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .gps_sec(gps_sec),
    .consume(tag), .pend(pend), .pend_sec(pend_sec), .last_sec(last_sec)
  );

  psp_sample_store #(.DEPTH(MAX_SAMPLES), .W(64)) u_store (
    .clk(clk), .we(accept), .waddr(AW'(cnt_q)), .wdata(in_data),
    .raddr(raddr), .rdata(rdata)
  );

  psp_byte_emitter #(.MAX_SAMPLES(MAX_SAMPLES)) u_emit (
    .clk(clk), .rst_n(rst_n), .start(close), .fmt(cur_fmt), .le(cur_le),
    .hdr_cnt(hdr_cnt), .hdr_mark(hdr_mark), .hdr_sec(hdr_sec), .hdr_idx(hdr_idx),
    .rdata(rdata), .raddr(raddr), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .done(emit_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cur_len  <= CW'(1);
      cur_fmt  <= '0;
      cur_le   <= 1'b0;
      mark_q   <= 1'b0;
      midx_q   <= '0;
      msec_q   <= '0;
      hdr_cnt  <= CW'(1);
      hdr_mark <= 1'b0;
      hdr_idx  <= 16'hFFFF;
      hdr_sec  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (boundary) begin
        cur_fmt <= cfg_fmt;
        cur_le  <= cfg_le;
        cur_len <= req_len;
      end
      if (close) begin
        cnt_q    <= '0;
        hdr_cnt  <= cnt_q + CW'(1);
        hdr_mark <= mark_q || tag;
        hdr_idx  <= tag ? 16'(cnt_q) : (mark_q ? midx_q : 16'hFFFF);
        hdr_sec  <= tag ? pend_sec : (mark_q ? msec_q : last_sec);
        mark_q   <= 1'b0;
      end else if (accept) begin
        cnt_q <= cnt_q + CW'(1);
        if (tag) begin
          mark_q <= 1'b1;
          midx_q <= 16'(cnt_q);
          msec_q <= pend_sec;
        end
      end
      if (in_valid && !in_ready && out_valid && !out_ready) ovf_q <= 1'b1;
    end
  end

  // R11: overflow is sticky
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R6: a closing sample starts a packet on the next cycle
  a_r6_close_starts: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> out_valid && out_sop);
  // R8: the mark index falls inside the packet
  a_r8_mark_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && hdr_mark |-> (32'(hdr_idx) < 32'(hdr_cnt)));
  // R9: no mark means the empty index code
  a_r9_no_mark_idx: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !hdr_mark |-> hdr_idx == 16'hFFFF);
  // R10: emission ends before more input is taken
  a_r10_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    emit_done |=> in_ready && !out_valid);
endmodule

// File: tb/psp_packetizer_test.sv
`timescale 1ns/1ps
module psp_packetizer_test;
  localparam int MAXS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_fmt = '0;
  logic        cfg_le = 1'b0;
  logic [15:0] cfg_pkt_len = 16'd4;
  logic        pps_in = 1'b0;
  logic [31:0] gps_sec = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_sop, out_eop, overflow;

  psp_packetizer #(.MAX_SAMPLES(MAXS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_le(cfg_le), .cfg_pkt_len(cfg_pkt_len),
    .pps_in(pps_in), .gps_sec(gps_sec), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .overflow(overflow)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [9:0] v;
    string      req;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [31:0] last_sec = '0;
  logic [15:0] lfsr = 16'hACE1;
  bit rnd_en = 1'b0;
  bit hold = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // output ready pattern
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = hold ? 1'b0 : (rnd_en ? (lfsr[0] | lfsr[2]) : 1'b1);
  end

  // monitor: compare each transferred byte with the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && !finished) begin
      if (q.size() == 0) chk(1'b0, "R1", "unexpected byte", out_data, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk({out_sop, out_eop, out_data} == e.v, e.req, "sop/eop/byte",
            {out_sop, out_eop, out_data}, e.v);
      end
    end
  end

  task automatic send_sample(input logic [63:0] d);
    in_valid = 1'b1;
    in_data  = d;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic add_field(inout logic [7:0] bq[$], inout string rq[$],
                           input logic [31:0] v, input int nb, input bit le, input string req);
    for (int b = 0; b < nb; b++) begin
      int sh;
      sh = le ? b : nb - 1 - b;
      bq.push_back(8'(v >> (8 * sh)));
      rq.push_back(req);
    end
  endtask

  // build the expected packet, drive its samples, wait for it to drain
  task automatic run_pkt(input logic [1:0] fmt, input bit le, input logic [15:0] len_cfg,
                         input int mark_at, input logic [31:0] sec, input bit chg);
    logic [7:0]  bq[$];
    string       rq[$];
    logic [63:0] smp[MAXS];
    int          n;
    logic [31:0] hsec;
    logic [15:0] hidx;
    string       treq, preq;
    n = (len_cfg == 0) ? 1 : ((int'(len_cfg) > MAXS) ? MAXS : int'(len_cfg));
    hsec = (mark_at >= 0) ? sec : last_sec;
    hidx = (mark_at >= 0) ? 16'(mark_at) : 16'hFFFF;
    treq = (mark_at >= 0) ? "R8" : "R9";
    preq = le ? "R5" : ((fmt == 2'd0) ? "R2" : ((fmt == 2'd1) ? "R3" : "R4"));
    bq.push_back({6'b0, fmt});            rq.push_back("R1");
    bq.push_back({7'b0, mark_at >= 0});   rq.push_back(treq);
    add_field(bq, rq, 32'(n), 2, 1'b0, "R6");
    add_field(bq, rq, hsec, 4, 1'b0, treq);
    add_field(bq, rq, {16'h0, hidx}, 2, 1'b0, treq);
    add_field(bq, rq, 32'h0, 2, 1'b0, "R1");
    for (int i = 0; i < n; i++) begin
      smp[i] = {$urandom, $urandom};
      case (fmt)
        2'd0: begin
          add_field(bq, rq, {16'h0, smp[i][47:32]}, 2, le, preq);
          add_field(bq, rq, {16'h0, smp[i][15:0]}, 2, le, preq);
        end
        2'd1: add_field(bq, rq, {16'h0, smp[i][15:0]}, 2, le, preq);
        default: begin
          add_field(bq, rq, smp[i][63:32], 4, le, preq);
          add_field(bq, rq, smp[i][31:0], 4, le, preq);
        end
      endcase
    end
    for (int j = 0; j < bq.size(); j++) begin
      exp_t e;
      e.v   = {j == 0, j == bq.size() - 1, bq[j]};
      e.req = chg ? "R7" : rq[j];
      q.push_back(e);
    end
    cfg_fmt = fmt; cfg_le = le; cfg_pkt_len = len_cfg;
    for (int i = 0; i < n; i++) begin
      if (i == mark_at) begin
        gps_sec = sec;
        @(posedge clk); #1;
        pps_in = 1'b1;
        repeat (6) @(posedge clk);
        #1;
      end
      send_sample(smp[i]);
      if (chg && i == 0) begin
        cfg_fmt = fmt + 2'd1; cfg_le = ~le; cfg_pkt_len = 16'd2;
      end
    end
    while (q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
    pps_in = 1'b0;
    if (mark_at >= 0) last_sec = sec;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R12", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R12", "out_valid after reset", out_valid, 0);
    chk(overflow == 1'b0, "R12", "overflow after reset", overflow, 0);
    @(posedge clk); #1;

    run_pkt(2'd0, 1'b0, 16'd4, -1, 32'h0, 1'b0);          // R2, R9 seconds 0
    rnd_en = 1'b1;
    run_pkt(2'd1, 1'b0, 16'd5, 2, 32'h12345678, 1'b0);    // R3, R8
    run_pkt(2'd2, 1'b0, 16'd3, -1, 32'h0, 1'b0);          // R4, R9 last seconds
    run_pkt(2'd0, 1'b1, 16'd4, -1, 32'h0, 1'b0);          // R5
    run_pkt(2'd2, 1'b1, 16'd2, -1, 32'h0, 1'b0);          // R5
    run_pkt(2'd1, 1'b1, 16'd3, 0, 32'h00ABCDEF, 1'b0);    // R5, R8 at index 0
    run_pkt(2'd3, 1'b0, 16'd2, -1, 32'h0, 1'b0);          // R4 code 3
    run_pkt(2'd1, 1'b0, 16'd0, -1, 32'h0, 1'b0);          // R6 zero -> 1
    run_pkt(2'd0, 1'b0, 16'd40, -1, 32'h0, 1'b0);         // R6 clamp to max
    run_pkt(2'd0, 1'b0, 16'd4, -1, 32'h0, 1'b1);          // R7 mid-packet config change
    run_pkt(2'd2, 1'b0, 16'd4, 3, 32'hCAFE0001, 1'b0);    // R8 mark on closing sample
    run_pkt(2'd1, 1'b0, 16'd2, -1, 32'h0, 1'b0);          // R9 after mark

    chk(overflow == 1'b0, "R11", "overflow before stall", overflow, 0);
    rnd_en = 1'b0;
    hold = 1'b1;
    begin
      exp_t e;
      logic [63:0] d;
      logic [7:0] held;
      d = {$urandom, $urandom};
      e.v = {2'b10, 8'h01}; e.req = "R1"; q.push_back(e);
      e.v = {2'b00, 8'h00}; e.req = "R9"; q.push_back(e);
      e.v = {2'b00, 8'h00}; e.req = "R6"; q.push_back(e);
      e.v = {2'b00, 8'h01}; e.req = "R6"; q.push_back(e);
      for (int b = 3; b >= 0; b--) begin
        e.v = {2'b00, 8'(last_sec >> (8 * b))}; e.req = "R9"; q.push_back(e);
      end
      e.v = {2'b00, 8'hFF}; e.req = "R9"; q.push_back(e);
      q.push_back(e);
      e.v = {2'b00, 8'h00}; e.req = "R1"; q.push_back(e);
      q.push_back(e);
      e.v = {2'b00, d[15:8]}; e.req = "R3"; q.push_back(e);
      e.v = {2'b01, d[7:0]};  e.req = "R3"; q.push_back(e);
      cfg_fmt = 2'd1; cfg_le = 1'b0; cfg_pkt_len = 16'd1;
      send_sample(d);
      @(negedge clk);
      held = out_data;
      chk(out_valid == 1'b1, "R10", "valid while stalled", out_valid, 1);
      @(posedge clk); #1;
      in_valid = 1'b1;
      @(posedge clk); #1;
      in_valid = 1'b0;
      @(negedge clk);
      chk(in_ready == 1'b0, "R10", "in_ready during emission", in_ready, 0);
      chk(out_data == held, "R10", "held byte", out_data, held);
      chk(out_sop == 1'b1, "R10", "held sop", out_sop, 1);
      chk(overflow == 1'b1, "R11", "overflow on stalled input", overflow, 1);
      @(posedge clk); #1;
      hold = 1'b0;
      while (q.size() != 0) @(posedge clk);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(overflow == 1'b1, "R11", "overflow sticky", overflow, 1);
      chk(in_ready == 1'b1, "R10", "in_ready after packet", in_ready, 1);
    end

    chk(q.size() == 0, "R1", "scoreboard drained", q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule